// File: doc/BRIEF.md
# Nine-Valued Logic Select, Invert, Conjunction and Edge Unit

This block works on signals that carry one of nine logic states: the two forcing levels, two weak levels, several unknown or undriven states and a don't-care. Each state travels as a 4-bit code. The unit offers four independent functions side by side.

- A two-way selector whose select input is itself nine-valued.
- A lane-wise inverter over a vector of `VEC_MAX` codes.
- A lane-wise AND of two vectors that each carry a declared length.
- A clocked detector that reports rising and falling transitions of one nine-valued signal, together with its plain-bit conversion.

The selector, the inverter and the AND are purely combinational. The edge detector keeps one register holding the previously sampled value. A surrounding datapath uses the unit wherever resolved multi-state values must be combined or watched without collapsing them to two states too early.

Top module: `nvl_unit`

## Requirements
- R1: State codes are U=0, X=1, forcing 0=2, forcing 1=3, Z=4, W=5, L (weak 0)=6, H (weak 1)=7, don't-care=8. Any input code from 9 to 15, on any input, is handled exactly as X (code 1).
- R2: When `sel` is forcing 0 or L, `mux_y` equals `mux_a`. When `sel` is forcing 1 or H, `mux_y` equals `mux_b`. In both cases an illegal data code is delivered as X.
- R3: When `sel` is U, X, Z, W or don't-care, `mux_y` is X whatever the data inputs hold.
- R4: Each lane of `not_out` (lane i at bits 4i+3..4i) is the inversion of the same lane of `not_in`: U→U, X→X, forcing 0→forcing 1, forcing 1→forcing 0, Z→X, W→X, L→forcing 1, H→forcing 0, don't-care→X.
- R5: With equal lengths, lane i below the length gives the AND of the two operands' lane i. The result is forcing 0 if either operand is forcing 0 or L. Otherwise it is forcing 1 if both are in {forcing 1, H}. Otherwise it is U if either is U. Every remaining case gives X.
- R6: When `len_a` differs from `len_b`, `and_err` is 1 and every bit of `and_out` is 0. When the lengths are equal, `and_err` is 0.
- R7: With equal lengths, every lane at or above the length reads as all-zero bits.
- R8: `edge_rise` is 1 only when three conditions hold at once. First, `edge_in` differs from the previously sampled value. Second, `edge_in` reduces to 1. Third, the previous value reduces to 0. Reduction maps forcing 0 and L to 0, maps forcing 1 and H to 1, and maps everything else to X.
- R9: `edge_fall` is the mirror case of R8: the current value reduces to 0, the previous value reduces to 1, and the two values differ.
- R10: Reset loads the previous-value register with U, so neither edge output fires on the first sample after reset. Both edge outputs are 0 during reset.
- R11: `edge_bit` is 1 when `edge_in` is forcing 1 or H, and 0 for every other code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the edge detector |
| rst_n | input | 1 | Active-low reset |
| sel | input | 4 | Nine-valued selector code |
| mux_a | input | 4 | Selector data input taken on a low select |
| mux_b | input | 4 | Selector data input taken on a high select |
| mux_y | output | 4 | Selector result |
| not_in | input | 4*VEC_MAX | Inverter operand vector |
| not_out | output | 4*VEC_MAX | Inverted vector |
| and_a | input | 4*VEC_MAX | First AND operand vector |
| and_b | input | 4*VEC_MAX | Second AND operand vector |
| len_a | input | $clog2(VEC_MAX+1) | Length of the first operand |
| len_b | input | $clog2(VEC_MAX+1) | Length of the second operand |
| and_out | output | 4*VEC_MAX | AND result vector |
| and_err | output | 1 | Length mismatch flag |
| edge_in | input | 4 | Watched nine-valued signal |
| edge_rise | output | 1 | Rising transition seen |
| edge_fall | output | 1 | Falling transition seen |
| edge_bit | output | 1 | Plain-bit conversion of `edge_in` |

## Verification
The bench builds the unit with `VEC_MAX` set to 4 instead of the default 8. At that width all 256 operand pairs of the 4-bit code space fit into 64 vectors, so the AND table is checked exhaustively, illegal codes included. Every length from 0 to the full width is also reachable, which exercises both the zeroed tail and the mismatch flag. The edge sequence runs through weak and forcing levels, illegal codes and level-preserving changes, and it includes the first sample after reset.

// File: rtl/nvl_pkg.sv
package nvl_pkg;
   typedef logic [3:0] nv_t;

   localparam nv_t NV_U  = 4'd0;
   localparam nv_t NV_X  = 4'd1;
   localparam nv_t NV_F0 = 4'd2;
   localparam nv_t NV_F1 = 4'd3;
   localparam nv_t NV_Z  = 4'd4;
   localparam nv_t NV_W  = 4'd5;
   localparam nv_t NV_L  = 4'd6;
   localparam nv_t NV_H  = 4'd7;
   localparam nv_t NV_DC = 4'd8;

   // Out-of-range codes behave as forcing unknown.
   function automatic nv_t nv_clean(nv_t c);
      return (c > NV_DC) ? NV_X : c;
   endfunction

   // Reduction onto the three-state X/0/1 scale.
   function automatic nv_t nv_x01(nv_t c);
      nv_t v;
      v = nv_clean(c);
      if (v == NV_F0 || v == NV_L) return NV_F0;
      if (v == NV_F1 || v == NV_H) return NV_F1;
      return NV_X;
   endfunction

   function automatic nv_t nv_not(nv_t c);
      nv_t v;
      v = nv_clean(c);
      unique case (v)
         NV_U:        return NV_U;
         NV_F0, NV_L: return NV_F1;
         NV_F1, NV_H: return NV_F0;
         default:     return NV_X;
      endcase
   endfunction

   function automatic nv_t nv_and(nv_t a, nv_t b);
      nv_t ra, rb;
      ra = nv_x01(a);
      rb = nv_x01(b);
      if (ra == NV_F0 || rb == NV_F0) return NV_F0;
      if (ra == NV_F1 && rb == NV_F1) return NV_F1;
      if (nv_clean(a) == NV_U || nv_clean(b) == NV_U) return NV_U;
      return NV_X;
   endfunction

   function automatic logic nv_bit(nv_t c);
      return (nv_x01(c) == NV_F1);
   endfunction
endpackage

// File: rtl/nvl_mux.sv
module nvl_mux
   import nvl_pkg::*;
(
   input  logic [3:0] sel,
   input  logic [3:0] a,
   input  logic [3:0] b,
   output logic [3:0] y
);
   nv_t sel_lvl;

   always_comb begin
      sel_lvl = nv_x01(sel);
      if (sel_lvl == NV_F0)      y = nv_clean(a);
      else if (sel_lvl == NV_F1) y = nv_clean(b);
      else                       y = NV_X;
   end

   always_comb begin
      if (sel == NV_U || sel == NV_X || sel == NV_Z || sel == NV_W ||
          sel == NV_DC || sel > 4'd8)
         a_r3_unknown_sel: assert (y == NV_X);
   end
endmodule

// File: rtl/nvl_vec_not.sv
module nvl_vec_not
   import nvl_pkg::*;
#(
   parameter int LANES = 8
) (
   input  logic [4*LANES-1:0] vin,
   output logic [4*LANES-1:0] vout
);
   for (genvar i = 0; i < LANES; i++) begin : g_lane
      nv_t lane_in, lane_out;
      assign lane_in  = vin[4*i +: 4];
      assign lane_out = nv_not(lane_in);
      assign vout[4*i +: 4] = lane_out;

      always_comb begin
         if (lane_in == NV_F0 || lane_in == NV_L)
            a_r4_low_inverts: assert (vout[4*i +: 4] == NV_F1);
      end
   end
endmodule

// File: rtl/nvl_vec_and.sv
module nvl_vec_and
   import nvl_pkg::*;
#(
   parameter int LANES = 8,
   parameter int LEN_W = 4
) (
   input  logic [4*LANES-1:0] va,
   input  logic [4*LANES-1:0] vb,
   input  logic [LEN_W-1:0]   len_a,
   input  logic [LEN_W-1:0]   len_b,
   output logic [4*LANES-1:0] vout,
   output logic               err
);
   logic mismatch;
   assign mismatch = (len_a != len_b);
   assign err      = mismatch;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      nv_t la, lb;
      logic live;
      assign la   = va[4*i +: 4];
      assign lb   = vb[4*i +: 4];
      assign live = !mismatch && (i < int'(len_a));
      assign vout[4*i +: 4] = live ? nv_and(la, lb) : 4'd0;

      always_comb begin
         if (!err && (i < int'(len_a)) &&
             (la == NV_F0 || la == NV_L || lb == NV_F0 || lb == NV_L))
            a_r5_low_dominates: assert (vout[4*i +: 4] == NV_F0);
      end
   end

   always_comb begin
      if (len_a != len_b)
         a_r6_mismatch_zero: assert (vout == '0);
   end
endmodule

// File: rtl/nvl_edge.sv
module nvl_edge
   import nvl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] sig,
   output logic       rise,
   output logic       fall,
   output logic       bitv
);
   nv_t prev_q;
   logic seen_q;
   logic changed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= NV_U;
         seen_q <= 1'b0;
      end else begin
         prev_q <= nv_clean(sig);
         seen_q <= 1'b1;
      end
   end

   assign changed = (nv_clean(sig) != prev_q);
   assign rise = rst_n && changed && nv_x01(sig) == NV_F1 && nv_x01(prev_q) == NV_F0;
   assign fall = rst_n && changed && nv_x01(sig) == NV_F0 && nv_x01(prev_q) == NV_F1;
   assign bitv = nv_bit(sig);

   a_r8_rise_from_low: assert property (@(posedge clk) disable iff (!rst_n)
      rise |-> seen_q && nv_x01($past(sig)) == NV_F0);
   a_r9_fall_from_high: assert property (@(posedge clk) disable iff (!rst_n)
      fall |-> seen_q && nv_x01($past(sig)) == NV_F1);
   a_r8_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise && fall));
   a_r10_quiet_first: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_q |-> !rise && !fall);
endmodule

// File: rtl/nvl_unit.sv
module nvl_unit
   import nvl_pkg::*;
#(
   parameter int VEC_MAX = 8,
   localparam int LEN_W = $clog2(VEC_MAX + 1),
   localparam int VW    = 4 * VEC_MAX
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       sel,
   input  logic [3:0]       mux_a,
   input  logic [3:0]       mux_b,
   output logic [3:0]       mux_y,
   input  logic [VW-1:0]    not_in,
   output logic [VW-1:0]    not_out,
   input  logic [VW-1:0]    and_a,
   input  logic [VW-1:0]    and_b,
   input  logic [LEN_W-1:0] len_a,
   input  logic [LEN_W-1:0] len_b,
   output logic [VW-1:0]    and_out,
   output logic             and_err,
   input  logic [3:0]       edge_in,
   output logic             edge_rise,
   output logic             edge_fall,
   output logic             edge_bit
);
   if (VEC_MAX < 1) begin : g_bad_width
      $error("nvl_unit: VEC_MAX must be at least 1");
   end

   nvl_mux u_mux (.sel(sel), .a(mux_a), .b(mux_b), .y(mux_y));

   nvl_vec_not #(.LANES(VEC_MAX)) u_not (.vin(not_in), .vout(not_out));

   nvl_vec_and #(.LANES(VEC_MAX), .LEN_W(LEN_W)) u_and (
      .va(and_a), .vb(and_b), .len_a(len_a), .len_b(len_b),
      .vout(and_out), .err(and_err)
   );

   nvl_edge u_edge (
      .clk(clk), .rst_n(rst_n), .sig(edge_in),
      .rise(edge_rise), .fall(edge_fall), .bitv(edge_bit)
   );
endmodule

// File: tb/nvl_unit_tb.sv
module nvl_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N  = 4;
   localparam int LW = $clog2(N + 1);
   localparam int VW = 4 * N;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [3:0] sel = 4'd2, mux_a = 4'd0, mux_b = 4'd0;
   logic [VW-1:0] not_in = '0, and_a = '0, and_b = '0;
   logic [LW-1:0] len_a = LW'(N), len_b = LW'(N);
   logic [3:0] edge_in = 4'd2;
   logic [3:0] mux_y;
   logic [VW-1:0] not_out, and_out;
   logic and_err, edge_rise, edge_fall, edge_bit;

   int checks = 0;
   int fails = 0;
   int nstep = 0;
   logic [3:0] mprev = 4'd0;
   logic [3:0] eseq [17] = '{4'd3, 4'd2, 4'd3, 4'd7, 4'd6, 4'd7, 4'd1, 4'd3,
                            4'd2, 4'd5, 4'd2, 4'd12, 4'd7, 4'd4, 4'd8, 4'd2, 4'd6};

   typedef struct {
      logic [3:0] mux;
      logic [VW-1:0] nv, av;
      logic err, rise, fall, bitv;
      string mtag, atag, etag;
   } exp_t;
   exp_t sb [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   nvl_unit #(.VEC_MAX(N)) u_dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .mux_a(mux_a), .mux_b(mux_b),
      .mux_y(mux_y), .not_in(not_in), .not_out(not_out), .and_a(and_a),
      .and_b(and_b), .len_a(len_a), .len_b(len_b), .and_out(and_out),
      .and_err(and_err), .edge_in(edge_in), .edge_rise(edge_rise),
      .edge_fall(edge_fall), .edge_bit(edge_bit)
   );

   // Independent reference model written from the requirements.
   function automatic logic [3:0] m_cl(logic [3:0] c);
      return (c >= 4'd9) ? 4'd1 : c;
   endfunction
   function automatic logic [3:0] m_lvl(logic [3:0] c);
      case (m_cl(c))
         4'd2, 4'd6: return 4'd2;
         4'd3, 4'd7: return 4'd3;
         default:    return 4'd1;
      endcase
   endfunction
   function automatic logic [3:0] m_not(logic [3:0] c);
      case (m_cl(c))
         4'd0: return 4'd0;
         4'd2: return 4'd3;
         4'd3: return 4'd2;
         4'd6: return 4'd3;
         4'd7: return 4'd2;
         default: return 4'd1;
      endcase
   endfunction
   function automatic logic [3:0] m_and(logic [3:0] a, logic [3:0] b);
      logic [3:0] ca, cb;
      ca = m_cl(a);
      cb = m_cl(b);
      if (ca == 4'd2 || ca == 4'd6 || cb == 4'd2 || cb == 4'd6) return 4'd2;
      if ((ca == 4'd3 || ca == 4'd7) && (cb == 4'd3 || cb == 4'd7)) return 4'd3;
      if (ca == 4'd0 || cb == 4'd0) return 4'd0;
      return 4'd1;
   endfunction

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   // Driver: applies one staged input set, pushes the expected outputs.
   task automatic step(logic [3:0] s_sel, logic [3:0] s_a, logic [3:0] s_b,
                       logic [VW-1:0] s_n, logic [VW-1:0] s_x, logic [VW-1:0] s_y,
                       logic [LW-1:0] s_la, logic [LW-1:0] s_lb);
      exp_t e;
      logic [3:0] ev;
      @(posedge clk);
      #1;
      ev = eseq[nstep % 17];
      rst_n = 1'b1;
      sel = s_sel; mux_a = s_a; mux_b = s_b; not_in = s_n;
      and_a = s_x; and_b = s_y; len_a = s_la; len_b = s_lb; edge_in = ev;
      if (m_lvl(s_sel) == 4'd2)      e.mux = m_cl(s_a);
      else if (m_lvl(s_sel) == 4'd3) e.mux = m_cl(s_b);
      else                           e.mux = 4'd1;
      e.mtag = (s_sel > 4'd8 || s_a > 4'd8 || s_b > 4'd8) ? "R1" :
               (m_lvl(s_sel) == 4'd1) ? "R3" : "R2";
      for (int i = 0; i < N; i++) e.nv[4*i +: 4] = m_not(s_n[4*i +: 4]);
      e.err = (s_la != s_lb);
      for (int i = 0; i < N; i++)
         e.av[4*i +: 4] = (!e.err && i < int'(s_la)) ?
                          m_and(s_x[4*i +: 4], s_y[4*i +: 4]) : 4'd0;
      e.atag = e.err ? "R6" : (int'(s_la) < N) ? "R7" : "R5";
      e.rise = (m_cl(ev) != mprev) && m_lvl(ev) == 4'd3 && m_lvl(mprev) == 4'd2;
      e.fall = (m_cl(ev) != mprev) && m_lvl(ev) == 4'd2 && m_lvl(mprev) == 4'd3;
      e.bitv = (m_lvl(ev) == 4'd3);
      e.etag = (nstep == 0) ? "R10" : "R8";
      sb.push_back(e);
      mprev = m_cl(ev);
      nstep++;
   endtask

   // Monitor: compares the design against the scoreboard head.
   always @(negedge clk) begin
      if (sb.size() > 0) begin
         exp_t e;
         e = sb.pop_front();
         chk(e.mtag, "mux_y", 64'(mux_y), 64'(e.mux));
         chk("R4", "not_out", 64'(not_out), 64'(e.nv));
         chk(e.atag, "and_out", 64'(and_out), 64'(e.av));
         chk("R6", "and_err", 64'(and_err), 64'(e.err));
         chk(e.etag, "edge_rise", 64'(edge_rise), 64'(e.rise));
         chk((e.etag == "R10") ? "R10" : "R9", "edge_fall", 64'(edge_fall), 64'(e.fall));
         chk("R11", "edge_bit", 64'(edge_bit), 64'(e.bitv));
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [VW-1:0] va, vb;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10", "edge_rise in reset", 64'(edge_rise), 64'd0);
      chk("R10", "edge_fall in reset", 64'(edge_fall), 64'd0);
      // R2 R3 R1: every select code, with distinct data
      for (int s = 0; s < 16; s++)
         step(4'(s), 4'd7, 4'd4, '0, '0, '0, LW'(N), LW'(N));
      step(4'd6, 4'd13, 4'd3, '0, '0, '0, LW'(N), LW'(N));
      step(4'd7, 4'd2, 4'd15, '0, '0, '0, LW'(N), LW'(N));
      step(4'd1, 4'd3, 4'd3, '0, '0, '0, LW'(N), LW'(N));
      // R4: every code through the inverter
      for (int k = 0; k < 4; k++) begin
         for (int j = 0; j < N; j++) va[4*j +: 4] = 4'(k * N + j);
         step(4'd2, 4'd0, 4'd0, va, '0, '0, LW'(N), LW'(N));
      end
      // R5: exhaustive operand pairs at full length
      for (int k = 0; k < 64; k++) begin
         for (int j = 0; j < N; j++) begin
            va[4*j +: 4] = 4'((k * N + j) >> 4);
            vb[4*j +: 4] = 4'(k * N + j);
         end
         step(4'd3, 4'd0, 4'd0, '0, va, vb, LW'(N), LW'(N));
      end
      // R6 mismatch, R7 short and empty lengths
      va = {4'd3, 4'd7, 4'd3, 4'd0};
      vb = {4'd3, 4'd3, 4'd1, 4'd0};
      step(4'd2, 4'd0, 4'd0, '0, va, vb, LW'(3), LW'(4));
      step(4'd2, 4'd0, 4'd0, '0, va, vb, LW'(0), LW'(2));
      step(4'd2, 4'd0, 4'd0, '0, va, vb, LW'(2), LW'(2));
      step(4'd2, 4'd0, 4'd0, '0, va, vb, LW'(0), LW'(0));
      // R8 R9 R11: run the edge sequence fully once more
      for (int k = 0; k < 20; k++)
         step(4'd2, 4'd0, 4'd0, '0, '0, '0, LW'(N), LW'(N));
      @(posedge clk);
      @(negedge clk);
      #1;
      summary();
   end
endmodule